// File: doc/BRIEF.md
# Ping-Pong Receive Buffer with Destination Filter

This block takes an incoming frame as a byte stream, one byte per cycle, marked with start and last flags. It checks the six destination address bytes against a station address. A frame passes if it matches that address exactly, or if the top bit of its first byte is set, which marks a group address. A frame that passes is written into one of two byte buffers. On the last byte the block sets that buffer's full flag and can raise a one-cycle interrupt.

Software owns a buffer while its full flag is set. It gives the buffer back by writing the flag to zero. When ping-pong mode is on, the write pointer moves to the other buffer after each stored frame. When it is off, every frame goes to buffer 0. A frame that passes the filter but finds its buffer still full, or that is longer than the buffer, is dropped and counted as lost. A frame that fails the filter is dropped without any trace. The filter decides once the sixth byte has arrived. Bytes before that point are written into a free buffer speculatively, and the full flag is set only when the frame is accepted.

Top module: `rxb_pingpong_rx`

## Requirements
- R1: A frame whose first byte has bit 7 set passes the filter, whatever the station address is.
- R2: Any other frame passes only if its bytes 0..5 equal `mac_addr_i`, with byte 0 compared against bits 47:40. A frame that fails, or that has fewer than six bytes, is discarded silently: no full flag, no interrupt and no change to the lost count.
- R3: Byte i of an accepted frame can be read at byte index i of the buffer that took it.
- R4: In the cycle after the last byte of an accepted frame, bit 0 (full) of that buffer's control word reads 1.
- R5: A frame that passes the filter while the current buffer is full is dropped. The buffer contents stay unchanged and the lost count goes up by one.
- R6: A frame longer than BUF_BYTES bytes is not marked full and adds one to the lost count. A frame of exactly BUF_BYTES bytes is accepted.
- R7: `irq_o` is high for exactly one cycle, in the cycle after the last byte of an accepted frame. This happens only when bit 3 of buffer 0's control word and bit 31 of the global word are both set, whichever buffer took the frame.
- R8: With `pp_en_i` high, the pointer alternates 0,1,0,... on each accepted frame. With it low, frames are stored only in buffer 0.
- R9: After reset the pointer is on buffer 0, both control words and the global word read 0, the lost count is 0 and `irq_o` is low.
- R10: Writing a control word with bit 0 clear releases that buffer. Bit 3 is stored as written.
- R11: The lost count saturates at 2^LOST_W-1.
- R12: Word address map. With the MSB of the address clear, the low two bits select buffer 0 control (0), buffer 1 control (1), global (2) or lost count (3). With the MSB set, bit IDX_W selects the buffer and the bits below it give the byte index, and the byte is returned in `bus_rdata_o[7:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pp_en_i | input | 1 | Ping-pong mode enable |
| mac_addr_i | input | 48 | Station address, first byte in bits 47:40 |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_sof_i | input | 1 | First byte of frame |
| rx_eof_i | input | 1 | Last byte of frame |
| rx_data_i | input | 8 | Receive byte |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| irq_o | output | 1 | Receive interrupt pulse |

## Verification
The assertions check, on every cycle, that the interrupt never lasts more than one cycle and always follows a last byte. They also check that the pointer moves only right after a last byte, that it stays on buffer 0 while ping-pong is off, and that no buffer write lands beyond the buffer. Only the bench scenarios can show the rest: the filter decision for each destination byte position, the first-byte group sweep, the drop on a full buffer with the stored data left intact, the length boundary, the interrupt gating by the buffer 0 enable and the global enable, and saturation of the lost count.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int MAC_BYTES     = 6;
  localparam int CTRL_FULL_BIT = 0;
  localparam int CTRL_IE_BIT   = 3;
  localparam int GLB_IE_BIT    = 31;
  localparam logic [1:0] SEL_CTRL0 = 2'd0;
  localparam logic [1:0] SEL_CTRL1 = 2'd1;
  localparam logic [1:0] SEL_GLB   = 2'd2;
  localparam logic [1:0] SEL_LOST  = 2'd3;
endpackage

// File: rtl/rxb_frame_filter.sv
module rxb_frame_filter
  import rxb_pkg::*;
#(
  parameter int BUF_BYTES = 16,
  parameter int POS_W     = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sof_i,
  input  logic             eof_i,
  input  logic [7:0]       data_i,
  input  logic [47:0]      mac_i,
  output logic             byte_o,
  output logic [POS_W-1:0] pos_o,
  output logic             done_o,
  output logic             pass_o,
  output logic             ovf_o
);
  logic             in_q, match_q, group_q;
  logic [POS_W-1:0] pos_q;
  logic [7:0]       mac_b;
  logic             match_now, group_now, in_hdr;

  assign byte_o = valid_i & (sof_i | in_q);
  assign pos_o  = sof_i ? '0 : pos_q;
  assign done_o = byte_o & eof_i;
  assign ovf_o  = (pos_o == POS_W'(BUF_BYTES));
  assign in_hdr = (pos_o < POS_W'(MAC_BYTES));

  always_comb begin
    mac_b = '0;
    for (int k = 0; k < MAC_BYTES; k++)
      if (pos_o == POS_W'(k)) mac_b = mac_i[8*(MAC_BYTES-1-k) +: 8];
  end

  assign match_now = (sof_i | match_q) & (!in_hdr | (data_i == mac_b));
  assign group_now = sof_i ? data_i[7] : group_q;
  assign pass_o    = (pos_o >= POS_W'(MAC_BYTES-1)) & (group_now | match_now);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q    <= 1'b0;
      pos_q   <= '0;
      match_q <= 1'b0;
      group_q <= 1'b0;
    end else if (byte_o) begin
      in_q    <= !eof_i;
      pos_q   <= eof_i ? '0 : (ovf_o ? pos_o : pos_o + POS_W'(1));
      match_q <= match_now;
      group_q <= group_now;
    end
  end
endmodule

// File: rtl/rxb_ctrl.sv
module rxb_ctrl
  import rxb_pkg::*;
#(
  parameter int LOST_W = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pp_en_i,
  input  logic        first_i,
  input  logic        byte_i,
  input  logic        done_i,
  input  logic        pass_i,
  input  logic        ovf_i,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_sel_i,
  input  logic        wr_full_i,
  input  logic        wr_ie_i,
  input  logic        wr_gie_i,
  output logic [31:0] reg_rdata_o,
  output logic        cur_o,
  output logic        wr_en_o,
  output logic        irq_o
);
  logic [1:0]        full_q, ie_q;
  logic              gie_q, cur_q, blk_q, irq_q;
  logic [LOST_W-1:0] lost_q;
  logic              blk_now, accept, lost_ev;

  assign blk_now = first_i ? full_q[cur_q] : blk_q;
  assign wr_en_o = byte_i & !blk_now & !ovf_i;
  assign accept  = done_i & pass_i & !blk_now & !ovf_i;
  assign lost_ev = done_i & pass_i & !accept;
  assign cur_o   = cur_q;
  assign irq_o   = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= '0;
      ie_q   <= '0;
      gie_q  <= 1'b0;
      cur_q  <= 1'b0;
      blk_q  <= 1'b0;
      irq_q  <= 1'b0;
      lost_q <= '0;
    end else begin
      if (byte_i) blk_q <= blk_now;
      if (reg_we_i) begin
        case (reg_sel_i)
          SEL_CTRL0: begin full_q[0] <= wr_full_i; ie_q[0] <= wr_ie_i; end
          SEL_CTRL1: begin full_q[1] <= wr_full_i; ie_q[1] <= wr_ie_i; end
          SEL_GLB:   gie_q <= wr_gie_i;
          default: ;
        endcase
      end
      // hardware set wins over a same-cycle release
      if (accept) begin
        full_q[cur_q] <= 1'b1;
        cur_q         <= pp_en_i ? ~cur_q : 1'b0;
      end
      irq_q <= accept & ie_q[0] & gie_q;
      if (lost_ev && (lost_q != '1)) lost_q <= lost_q + LOST_W'(1);
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_sel_i)
      SEL_CTRL0: begin
        reg_rdata_o[CTRL_FULL_BIT] = full_q[0];
        reg_rdata_o[CTRL_IE_BIT]   = ie_q[0];
      end
      SEL_CTRL1: begin
        reg_rdata_o[CTRL_FULL_BIT] = full_q[1];
        reg_rdata_o[CTRL_IE_BIT]   = ie_q[1];
      end
      SEL_GLB:  reg_rdata_o[GLB_IE_BIT] = gie_q;
      default:  reg_rdata_o[LOST_W-1:0] = lost_q;
    endcase
  end
endmodule

// File: rtl/rxb_buf_store.sv
module rxb_buf_store #(
  parameter int BUF_BYTES = 16,
  parameter int IDX_W     = 4,
  parameter int POS_W     = 5
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic             wbuf_i,
  input  logic [POS_W-1:0] widx_i,
  input  logic [7:0]       wdata_i,
  input  logic             rbuf_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [7:0]       rdata_o
);
  logic [7:0] rd [2];
  logic       in_range;

  assign in_range = (widx_i < POS_W'(BUF_BYTES));

  for (genvar g = 0; g < 2; g++) begin : g_buf
    logic [7:0] mem [BUF_BYTES];
    always_ff @(posedge clk_i) begin
      if (we_i && in_range && (wbuf_i == 1'(g)))
        mem[widx_i[IDX_W-1:0]] <= wdata_i;
    end
    assign rd[g] = mem[ridx_i];
  end

  assign rdata_o = rd[rbuf_i];
endmodule

// File: rtl/rxb_pingpong_rx.sv
module rxb_pingpong_rx
  import rxb_pkg::*;
#(
  parameter int BUF_BYTES = 16,
  parameter int LOST_W    = 4,
  localparam int IDX_W    = $clog2(BUF_BYTES),
  localparam int POS_W    = IDX_W + 1,
  localparam int ADDR_W   = IDX_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pp_en_i,
  input  logic [47:0]       mac_addr_i,
  input  logic              rx_valid_i,
  input  logic              rx_sof_i,
  input  logic              rx_eof_i,
  input  logic [7:0]        rx_data_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o
);
  logic             byte_w, done_w, pass_w, ovf_w, cur_w, wr_en_w;
  logic [POS_W-1:0] pos_w;
  logic [31:0]      reg_rd;
  logic [7:0]       buf_rd;
  logic             is_data;
  logic             unused_wdata;

  assign is_data      = bus_addr_i[ADDR_W-1];
  assign unused_wdata = ^{bus_wdata_i[30:4], bus_wdata_i[2:1]};

  rxb_frame_filter #(.BUF_BYTES(BUF_BYTES), .POS_W(POS_W)) u_filter (
    .clk_i, .rst_ni,
    .valid_i(rx_valid_i), .sof_i(rx_sof_i), .eof_i(rx_eof_i),
    .data_i(rx_data_i), .mac_i(mac_addr_i),
    .byte_o(byte_w), .pos_o(pos_w), .done_o(done_w),
    .pass_o(pass_w), .ovf_o(ovf_w)
  );

  rxb_ctrl #(.LOST_W(LOST_W)) u_ctrl (
    .clk_i, .rst_ni, .pp_en_i,
    .first_i(rx_valid_i & rx_sof_i), .byte_i(byte_w), .done_i(done_w),
    .pass_i(pass_w), .ovf_i(ovf_w),
    .reg_we_i(bus_we_i & !is_data), .reg_sel_i(bus_addr_i[1:0]),
    .wr_full_i(bus_wdata_i[CTRL_FULL_BIT]), .wr_ie_i(bus_wdata_i[CTRL_IE_BIT]),
    .wr_gie_i(bus_wdata_i[GLB_IE_BIT]),
    .reg_rdata_o(reg_rd), .cur_o(cur_w), .wr_en_o(wr_en_w), .irq_o(irq_o)
  );

  rxb_buf_store #(.BUF_BYTES(BUF_BYTES), .IDX_W(IDX_W), .POS_W(POS_W)) u_store (
    .clk_i,
    .we_i(wr_en_w), .wbuf_i(cur_w), .widx_i(pos_w), .wdata_i(rx_data_i),
    .rbuf_i(bus_addr_i[IDX_W]), .ridx_i(bus_addr_i[IDX_W-1:0]),
    .rdata_o(buf_rd)
  );

  assign bus_rdata_o = is_data ? {24'h0, buf_rd} : reg_rd;
endmodule

// File: rtl/rxb_pingpong_rx_chk.sv
module rxb_pingpong_rx_chk #(
  parameter int BUF_BYTES = 16,
  parameter int POS_W     = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pp_en_i,
  input logic             rx_valid_i,
  input logic             rx_eof_i,
  input logic             irq_o,
  input logic             cur_w,
  input logic             wr_en_w,
  input logic [POS_W-1:0] pos_w
);
  a_r7_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  a_r7_irq_after_eof: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(rx_valid_i && rx_eof_i));

  a_r8_ptr_moves_on_eof: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_w != $past(cur_w)) |-> $past(rx_valid_i && rx_eof_i));

  a_r8_ptr_hold_pp_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(pp_en_i) && !$past(cur_w)) |-> !cur_w);

  a_r6_write_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_w |-> (pos_w < POS_W'(BUF_BYTES)));
endmodule

bind rxb_pingpong_rx rxb_pingpong_rx_chk #(.BUF_BYTES(BUF_BYTES), .POS_W(POS_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pp_en_i(pp_en_i),
  .rx_valid_i(rx_valid_i), .rx_eof_i(rx_eof_i), .irq_o(irq_o),
  .cur_w(cur_w), .wr_en_w(wr_en_w), .pos_w(pos_w)
);

// File: tb/tb_rxb_pingpong_rx.sv
module tb_rxb_pingpong_rx;
  localparam int BUF_BYTES = 16;
  localparam int LOST_W    = 4;
  localparam int ADDR_W    = 6;
  localparam int DATA0     = 32;
  localparam int DATA1     = 48;
  localparam logic [47:0] MAC = 48'h02_11_22_33_44_55;

  logic clk = 1'b0, rst_n = 1'b0, pp_en = 1'b1;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0;
  logic [7:0] rx_data = 0;
  logic bus_we = 0;
  logic [ADDR_W-1:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq;

  int total = 0, bad = 0, exp_lost = 0;
  logic [7:0] fr [32];
  logic [7:0] keep [32];

  always #5 clk = ~clk;

  rxb_pingpong_rx #(.BUF_BYTES(BUF_BYTES), .LOST_W(LOST_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pp_en_i(pp_en), .mac_addr_i(MAC),
    .rx_valid_i(rx_valid), .rx_sof_i(rx_sof), .rx_eof_i(rx_eof), .rx_data_i(rx_data),
    .bus_we_i(bus_we), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = ADDR_W'(a); bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); bus_addr = ADDR_W'(a); #1 d = bus_rdata;
  endtask

  task automatic mk_uni(input int seed, input int len);
    for (int i = 0; i < 32; i++)
      fr[i] = (i < 6) ? MAC[8*(5-i) +: 8] : 8'((seed*37 + i*11) & 255);
  endtask

  task automatic mk_grp(input int seed);
    for (int i = 0; i < 32; i++) fr[i] = 8'((seed*13 + i*29) & 255);
    fr[0] = fr[0] | 8'h80;
  endtask

  task automatic send(input int len, output logic irq_hit, output logic irq_extra);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = fr[i]; rx_sof = (i == 0); rx_eof = (i == len-1);
    end
    @(negedge clk); rx_valid = 0; rx_sof = 0; rx_eof = 0; irq_hit = irq;
    @(negedge clk); irq_extra = irq;
  endtask

  task automatic chk_buf(input string tag, input int base, input int len);
    logic [31:0] d;
    for (int i = 0; i < len; i++) begin
      rd(base + i, d);
      chk(tag, d, {24'h0, fr[i]});
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic ih, ix;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9 / R12 reset state
    rd(0, d); chk("R9 ctrl0", d, 0);
    rd(1, d); chk("R9 ctrl1", d, 0);
    rd(2, d); chk("R9 R12 global", d, 0);
    rd(3, d); chk("R9 lost", d, 0);
    chk("R9 irq", irq, 0);

    wr(2, 32'h8000_0000); wr(0, 32'h8);
    rd(2, d); chk("R12 global ie", d, 32'h8000_0000);

    // unicast to buffer 0
    mk_uni(1, 10); send(10, ih, ix);
    chk("R7 irq pulse", ih, 1); chk("R7 irq one cycle", ix, 0);
    rd(0, d); chk("R4 ctrl0 full", d, 32'h9);
    chk_buf("R3 buf0 data", DATA0, 10);
    for (int i = 0; i < 10; i++) keep[i] = fr[i];

    // group frame goes to buffer 1
    mk_grp(2); send(8, ih, ix);
    chk("R1 R7 irq", ih, 1);
    rd(1, d); chk("R1 R8 ctrl1 full", d, 32'h1);
    chk_buf("R3 buf1 data", DATA1, 8);

    // pointer back on full buffer 0
    mk_uni(3, 7); send(7, ih, ix); exp_lost++;
    chk("R5 no irq", ih, 0);
    rd(3, d); chk("R5 lost", d, exp_lost);
    for (int i = 0; i < 10; i++) begin
      rd(DATA0 + i, d); chk("R5 buf0 kept", d, {24'h0, keep[i]});
    end

    wr(0, 32'h8);
    rd(0, d); chk("R10 release", d, 32'h8);

    // mismatched unicast, short group
    mk_uni(4, 10); fr[5] = fr[5] ^ 8'h01; send(10, ih, ix);
    chk("R2 mismatch irq", ih, 0);
    rd(0, d); chk("R2 mismatch ctrl0", d, 32'h8);
    mk_grp(5); send(4, ih, ix);
    chk("R2 short irq", ih, 0);
    rd(0, d); chk("R2 short ctrl0", d, 32'h8);
    rd(3, d); chk("R2 lost unchanged", d, exp_lost);

    // length boundary
    mk_uni(6, 17); send(17, ih, ix); exp_lost++;
    chk("R6 long irq", ih, 0);
    rd(0, d); chk("R6 long ctrl0", d, 32'h8);
    rd(3, d); chk("R6 long lost", d, exp_lost);
    mk_uni(7, 16); send(16, ih, ix);
    chk("R6 exact irq", ih, 1);
    rd(0, d); chk("R6 exact ctrl0", d, 32'h9);
    chk_buf("R6 R3 exact data", DATA0, 16);

    // irq gated by buffer 0 enable only
    wr(1, 32'h8); wr(0, 32'h1);
    mk_grp(8); send(12, ih, ix);
    chk("R7 ie1 ignored", ih, 0);
    rd(1, d); chk("R7 R8 ctrl1", d, 32'h9);

    // saturation
    for (int n = 0; n < 16; n++) begin
      mk_grp(20 + n); send(6, ih, ix);
      if (exp_lost < 15) exp_lost++;
      chk("R11 no irq", ih, 0);
    end
    rd(3, d); chk("R11 saturate", d, 15);

    // global enable off
    wr(1, 32'h0); wr(0, 32'h8); wr(2, 32'h0);
    mk_grp(9); send(8, ih, ix);
    chk("R7 gie off", ih, 0);
    rd(0, d); chk("R7 gie off full", d, 32'h9);

    // ping-pong off after reset
    @(negedge clk); rst_n = 0; pp_en = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    rd(0, d); chk("R9 ctrl0 again", d, 0);
    rd(3, d); chk("R9 lost again", d, 0);
    wr(2, 32'h8000_0000); wr(0, 32'h8);
    for (int k = 0; k < 6; k++) begin
      mk_uni(10 + k, 9); fr[k] = fr[k] ^ 8'h01; send(9, ih, ix);
      chk("R2 byte flip irq", ih, 0);
      rd(0, d); chk("R2 byte flip ctrl0", d, 32'h8);
    end
    mk_uni(30, 9); send(9, ih, ix);
    chk("R2 match irq", ih, 1);
    rd(0, d); chk("R8 pp off ctrl0", d, 32'h9);
    wr(0, 32'h8);
    mk_uni(31, 11); send(11, ih, ix);
    rd(0, d); chk("R8 pp off buf0 again", d, 32'h9);
    rd(1, d); chk("R8 pp off ctrl1 idle", d, 0);
    chk_buf("R8 R3 buf0 second", DATA0, 11);

    // first-byte sweep
    for (int v = 0; v < 16; v++) begin
      wr(0, 32'h8);
      for (int i = 0; i < 32; i++) fr[i] = 8'h00;
      fr[0] = 8'(v*16 + 5);
      send(7, ih, ix);
      chk("R1 sweep irq", ih, (v >= 8));
      rd(0, d); chk("R1 sweep ctrl0", d, (v >= 8) ? 32'h9 : 32'h8);
    end
    rd(3, d); chk("R2 sweep lost", d, 0);

    finish_run();
  end
endmodule